// File: doc/BRIEF.md
# Byte-Cycle to 16-bit Drive Data Bridge

This block connects a host that can only make 8-bit I/O cycles to a drive whose data register is 16 bits wide. The host moves one data word as two byte cycles at two neighbouring addresses. The bridge keeps one byte in a holding register, so the drive sees a single 16-bit transfer. The seven 8-bit command and status registers of the drive sit at even host addresses. The drive register index is host address bits [3:1], and host address bit 0 selects the low half (0) or high half (1) of a data word.

The host strobes, address and data are synchronised to the system clock, and every drive-side output is registered. A sequencer with five states controls each access:
- `ST_IDLE` waits for a strobe inside the decoded window.
- `ST_STROBE` holds the drive strobe while the host strobe lasts.
- `ST_HOLD` keeps the drive strobe for `HOLD_CYCLES` more clocks.
- `ST_TAIL` keeps write data driven for `HOLD_CYCLES` clocks after the write strobe drops.
- `ST_LOCAL` serves accesses that the bridge answers itself.

The transitions are:
- IDLE→STROBE on a data-low read, a data-high write or a command access.
- IDLE→LOCAL on a data-low write, a data-high read or an odd command address.
- STROBE→HOLD when the host strobe is released.
- HOLD→TAIL on a write and HOLD→IDLE on a read, each when the hold count runs out.
- TAIL→IDLE when the count runs out.
- LOCAL→IDLE when the host strobe is released.

Top module: `isa_ata_bridge`

## Requirements
- R1: During and after reset, drv_rd, drv_wr, drv_dout_en and host_dout_en are all 0.
- R2: An access whose address bits [ADDR_W-1:4] differ from those of BASE_ADDR produces no drive strobe, and host_dout_en stays 0.
- R3: A read at host offset 0 (register 0, low half) asserts drv_rd with drv_reg = 0. It returns drv_din[7:0] on host_dout and captures drv_din[15:8] in the holding register.
- R4: A read at offset 1 (register 0, high half) makes no drive strobe. It returns the byte captured by the last offset-0 read.
- R5: A write at offset 0 only loads the holding register, with no drive strobe. A write at offset 1 asserts drv_wr with drv_reg = 0 and drv_dout = {host byte, held byte}.
- R6: An access at even offset 2·n (n = 1..7) strobes drive register n. A read returns drv_din[7:0]. A write drives {8'h00, host byte}.
- R7: An access at odd offset 2·n+1 (n = 1..7) makes no drive strobe. A read of it returns 8'hFF.
- R8: The drive strobe drops on the (HOLD_CYCLES+3)-th rising clock edge after the host strobe falls. That count is two synchroniser stages, one decision cycle and HOLD_CYCLES hold cycles.
- R9: drv_dout_en is 1 whenever drv_wr is 1. It stays 1, with drv_dout unchanged, for HOLD_CYCLES clocks after drv_wr falls, and then drops.
- R10: drv_rd and drv_wr are never 1 together, and drv_reg does not change while a drive strobe stays asserted.
- R11: Command-register accesses between the two halves of a data word leave the holding register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W | Host I/O address |
| host_rd | input | 1 | Host read strobe, active high |
| host_wr | input | 1 | Host write strobe, active high |
| host_din | input | 8 | Host write byte |
| host_dout | output | 8 | Byte returned to the host |
| host_dout_en | output | 1 | Host read data is being driven |
| drv_reg | output | 3 | Drive register index |
| drv_rd | output | 1 | Drive read strobe, active high |
| drv_wr | output | 1 | Drive write strobe, active high |
| drv_din | input | 16 | Data from the drive |
| drv_dout | output | 16 | Data to the drive |
| drv_dout_en | output | 1 | Drive data output enable |

## Verification
The main function is tried with six word patterns: all zeros, all ones, alternating bits, distinct nibbles, only the low byte set, and only the end bits set. Each word is written as two byte cycles and read back as two byte cycles, so a swapped half, a stuck bit or a stale holding register shows up as a mismatch in one particular byte. Separate sequences check the following:
- Command registers pass straight through.
- Odd command addresses are dropped.
- An address outside the window is dropped.
- A command access between the two halves of a word leaves the held byte intact.
- The strobe and data-hold release edges fall on the stated cycle.

// File: rtl/isa_ata_pkg.sv
package isa_ata_pkg;

    localparam int REG_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STROBE,
        ST_HOLD,
        ST_TAIL,
        ST_LOCAL
    } state_t;

    typedef enum logic [1:0] {
        ACC_DATA_LO,
        ACC_DATA_HI,
        ACC_CMD,
        ACC_VOID
    } acc_kind_t;

    typedef struct packed {
        acc_kind_t         kind;
        logic              is_wr;
        logic [REG_W-1:0]  idx;
    } access_t;

endpackage

// File: rtl/isa_ata_sync.sv
module isa_ata_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (STAGES <= 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q <= '0;
                else        q <= d;
            end
        end else begin : g_chain
            logic [STAGES*W-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[(STAGES-1)*W-1:0], d};
            end
            assign q = chain[STAGES*W-1 -: W];
        end
    endgenerate

endmodule

// File: rtl/isa_ata_decode.sv
module isa_ata_decode
    import isa_ata_pkg::*;
#(
    parameter int                ADDR_W    = 10,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h300
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              sel,
    output acc_kind_t         kind,
    output logic [REG_W-1:0]  idx
);

    localparam int WIN_LSB = REG_W + 1;

    logic half;

    assign sel  = (addr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB]);
    assign idx  = addr[REG_W:1];
    assign half = addr[0];

    always_comb begin
        if (idx == '0) begin
            kind = half ? ACC_DATA_HI : ACC_DATA_LO;
        end else begin
            kind = half ? ACC_VOID : ACC_CMD;
        end
    end

endmodule

// File: rtl/isa_ata_fsm.sv
module isa_ata_fsm
    import isa_ata_pkg::*;
#(
    parameter int HOLD_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_s,
    input  logic             wr_s,
    input  logic             sel,
    input  acc_kind_t        kind_in,
    input  logic [REG_W-1:0] idx_in,
    output state_t           state_q,
    output access_t          acc_d,
    output logic             start,
    output logic             drv_rd,
    output logic             drv_wr,
    output logic             drv_dout_en,
    output logic             host_dout_en,
    output logic [REG_W-1:0] drv_reg
);

    localparam int CNT_W = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES + 1);

    state_t            state_d;
    access_t           acc_q;
    logic [CNT_W-1:0]  cnt;
    logic              strobe_s;
    logic              goes_out;

    assign strobe_s = rd_s | wr_s;

    always_comb begin
        goes_out = 1'b0;
        unique case (kind_in)
            ACC_DATA_LO: goes_out = rd_s;
            ACC_DATA_HI: goes_out = !rd_s;
            ACC_CMD:     goes_out = 1'b1;
            ACC_VOID:    goes_out = 1'b0;
            default:     goes_out = 1'b0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        acc_d   = acc_q;
        start   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (strobe_s && sel) begin
                    start       = 1'b1;
                    acc_d.kind  = kind_in;
                    acc_d.is_wr = !rd_s;
                    acc_d.idx   = idx_in;
                    state_d     = goes_out ? ST_STROBE : ST_LOCAL;
                end
            end
            ST_STROBE: if (!strobe_s) state_d = ST_HOLD;
            ST_HOLD:   if (cnt == '0) state_d = acc_q.is_wr ? ST_TAIL : ST_IDLE;
            ST_TAIL:   if (cnt == '0) state_d = ST_IDLE;
            ST_LOCAL:  if (!strobe_s) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            acc_q   <= '{kind: ACC_VOID, is_wr: 1'b0, idx: '0};
        end else begin
            state_q <= state_d;
            acc_q   <= acc_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if ((state_d == ST_HOLD && state_q != ST_HOLD) ||
                     (state_d == ST_TAIL && state_q != ST_TAIL)) begin
            cnt <= CNT_W'(HOLD_CYCLES - 1);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_rd       <= 1'b0;
            drv_wr       <= 1'b0;
            drv_dout_en  <= 1'b0;
            host_dout_en <= 1'b0;
            drv_reg      <= '0;
        end else begin
            drv_rd       <= (state_d == ST_STROBE || state_d == ST_HOLD) && !acc_d.is_wr;
            drv_wr       <= (state_d == ST_STROBE || state_d == ST_HOLD) && acc_d.is_wr;
            drv_dout_en  <= (state_d == ST_STROBE || state_d == ST_HOLD ||
                             state_d == ST_TAIL) && acc_d.is_wr;
            host_dout_en <= (state_d == ST_STROBE || state_d == ST_HOLD ||
                             state_d == ST_LOCAL) && !acc_d.is_wr;
            if (start) drv_reg <= acc_d.idx;
        end
    end

endmodule

// File: rtl/isa_ata_datapath.sv
module isa_ata_datapath
    import isa_ata_pkg::*;
#(
    parameter int HOST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  acc_kind_t         kind,
    input  logic              is_wr,
    input  state_t            state_q,
    input  logic              drv_rd,
    input  logic [HOST_W-1:0] host_byte,
    input  logic [2*HOST_W-1:0] drv_din,
    output logic [HOST_W-1:0] host_dout,
    output logic [2*HOST_W-1:0] drv_dout
);

    logic [HOST_W-1:0] held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held      <= '0;
            host_dout <= '1;
            drv_dout  <= '0;
        end else if (start) begin
            unique case (kind)
                ACC_DATA_LO: if (is_wr) held <= host_byte;
                ACC_DATA_HI: begin
                    if (is_wr) drv_dout  <= {host_byte, held};
                    else       host_dout <= held;
                end
                ACC_CMD:     if (is_wr) drv_dout <= {{HOST_W{1'b0}}, host_byte};
                ACC_VOID:    if (!is_wr) host_dout <= '1;
                default:     ;
            endcase
        end else if (state_q == ST_STROBE && drv_rd) begin
            host_dout <= drv_din[HOST_W-1:0];
            if (kind == ACC_DATA_LO) held <= drv_din[2*HOST_W-1:HOST_W];
        end
    end

endmodule

// File: rtl/isa_ata_bridge.sv
module isa_ata_bridge
    import isa_ata_pkg::*;
#(
    parameter int                ADDR_W      = 10,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 10'h300,
    parameter int                HOLD_CYCLES = 2,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [7:0]        host_din,
    output logic [7:0]        host_dout,
    output logic              host_dout_en,
    output logic [2:0]        drv_reg,
    output logic              drv_rd,
    output logic              drv_wr,
    input  logic [15:0]       drv_din,
    output logic [15:0]       drv_dout,
    output logic              drv_dout_en
);

    localparam int HOST_W = 8;
    localparam int BUS_W  = ADDR_W + HOST_W + 2;

    logic [BUS_W-1:0]  bus_s;
    logic [ADDR_W-1:0] addr_s;
    logic [HOST_W-1:0] byte_s;
    logic              rd_s;
    logic              wr_s;
    logic              strobe_s;
    logic              sel;
    acc_kind_t         kind;
    logic [REG_W-1:0]  idx;
    state_t            state_q;
    access_t           acc_d;
    logic              start;

    isa_ata_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({host_addr, host_din, host_rd, host_wr}),
        .q     (bus_s)
    );

    assign {addr_s, byte_s, rd_s, wr_s} = bus_s;
    assign strobe_s = rd_s | wr_s;

    isa_ata_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
        .addr (addr_s),
        .sel  (sel),
        .kind (kind),
        .idx  (idx)
    );

    isa_ata_fsm #(.HOLD_CYCLES(HOLD_CYCLES)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_s         (rd_s),
        .wr_s         (wr_s),
        .sel          (sel),
        .kind_in      (kind),
        .idx_in       (idx),
        .state_q      (state_q),
        .acc_d        (acc_d),
        .start        (start),
        .drv_rd       (drv_rd),
        .drv_wr       (drv_wr),
        .drv_dout_en  (drv_dout_en),
        .host_dout_en (host_dout_en),
        .drv_reg      (drv_reg)
    );

    isa_ata_datapath #(.HOST_W(HOST_W)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .kind      (acc_d.kind),
        .is_wr     (acc_d.is_wr),
        .state_q   (state_q),
        .drv_rd    (drv_rd),
        .host_byte (byte_s),
        .drv_din   (drv_din),
        .host_dout (host_dout),
        .drv_dout  (drv_dout)
    );

endmodule

// File: rtl/isa_ata_bridge_chk.sv
module isa_ata_bridge_chk #(
    parameter int HOLD_CYCLES = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        strobe_s,
    input logic        drv_rd,
    input logic        drv_wr,
    input logic        drv_dout_en,
    input logic [15:0] drv_dout,
    input logic [2:0]  drv_reg
);

    localparam int RW = $clog2(HOLD_CYCLES + 3) + 1;

    logic [RW-1:0] rel_cnt;
    logic          drv_any;

    assign drv_any = drv_rd | drv_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  rel_cnt <= '0;
        else if (strobe_s || !drv_any) rel_cnt <= '0;
        else                         rel_cnt <= rel_cnt + 1'b1;
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(drv_rd && drv_wr)); // R10

    AST_REG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_any && $past(drv_any)) |-> $stable(drv_reg)); // R10

    AST_WR_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        drv_wr |-> drv_dout_en); // R9

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_wr) |-> (drv_dout_en && $stable(drv_dout))); // R9

    AST_RELEASE_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drv_any) |-> (rel_cnt == RW'(HOLD_CYCLES + 1))); // R8

endmodule

bind isa_ata_bridge isa_ata_bridge_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe_s    (strobe_s),
    .drv_rd      (drv_rd),
    .drv_wr      (drv_wr),
    .drv_dout_en (drv_dout_en),
    .drv_dout    (drv_dout),
    .drv_reg     (drv_reg)
);

// File: tb/test_isa_ata_bridge.sv
module test_isa_ata_bridge;

    localparam int          ADDR_W = 10;
    localparam logic [9:0]  BASE   = 10'h300;
    localparam int          HOLD   = 2;
    localparam int          NVEC   = 6;
    localparam logic [15:0] VEC [NVEC] = '{16'h0000, 16'hFFFF, 16'hA55A,
                                            16'h1234, 16'h00FF, 16'h8001};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  host_addr = '0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_din = '0;
    logic [7:0]  host_dout;
    logic        host_dout_en;
    logic [2:0]  drv_reg;
    logic        drv_rd;
    logic        drv_wr;
    logic [15:0] drv_din;
    logic [15:0] drv_dout;
    logic        drv_dout_en;

    int n_checks = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    isa_ata_bridge #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE), .HOLD_CYCLES(HOLD)) i_isa_ata_bridge (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
        .host_wr(host_wr), .host_din(host_din), .host_dout(host_dout),
        .host_dout_en(host_dout_en), .drv_reg(drv_reg), .drv_rd(drv_rd),
        .drv_wr(drv_wr), .drv_din(drv_din), .drv_dout(drv_dout),
        .drv_dout_en(drv_dout_en)
    );

    // drive model: register file of 16-bit words
    logic [15:0] regs [8];
    logic        wr_q = 1'b0;
    logic        rd_q = 1'b0;
    int          wr_rises = 0;
    int          rd_rises = 0;

    initial for (int i = 0; i < 8; i++) regs[i] = 16'hDEAD;

    assign drv_din = drv_rd ? regs[drv_reg] : 16'h0000;

    always @(posedge clk) begin
        wr_q <= drv_wr;
        rd_q <= drv_rd;
        if (drv_wr && !wr_q) begin
            wr_rises <= wr_rises + 1;
            regs[drv_reg] <= drv_dout;
        end
        if (drv_rd && !rd_q) rd_rises <= rd_rises + 1;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_cycle(input bit is_wr, input logic [9:0] addr,
                              input logic [7:0] d, output logic [7:0] q,
                              output logic en);
        @(negedge clk);
        host_addr = addr;
        host_din  = d;
        repeat (2) @(negedge clk);
        if (is_wr) host_wr = 1'b1; else host_rd = 1'b1;
        repeat (10) @(negedge clk);
        q  = host_dout;
        en = host_dout_en;
        host_wr = 1'b0;
        host_rd = 1'b0;
        repeat (2 * HOLD + 8) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog actual=%h expected=%h", 1, 0);
        $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] q;
        logic       en;
        int         w0;
        int         r0;

        // R1: reset state
        repeat (3) @(negedge clk);
        check({drv_rd, drv_wr, drv_dout_en, host_dout_en} == 4'b0000, "R1 in reset",
              {drv_rd, drv_wr, drv_dout_en, host_dout_en}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check({drv_rd, drv_wr, drv_dout_en, host_dout_en} == 4'b0000, "R1 after reset",
              {drv_rd, drv_wr, drv_dout_en, host_dout_en}, 0);

        // table of data words: two byte writes, two byte reads
        for (int i = 0; i < NVEC; i++) begin
            w0 = wr_rises;
            r0 = rd_rises;
            host_cycle(1'b1, BASE + 10'd0, VEC[i][7:0], q, en);
            check(wr_rises == w0, "R5 low write no strobe", wr_rises - w0, 0);
            host_cycle(1'b1, BASE + 10'd1, VEC[i][15:8], q, en);
            check(regs[0] == VEC[i], "R5 word at drive", regs[0], VEC[i]);
            check(wr_rises == w0 + 1, "R5 one drive write", wr_rises - w0, 1);
            host_cycle(1'b0, BASE + 10'd0, 8'h00, q, en);
            check(q == VEC[i][7:0] && en, "R3 low byte read", {en, q}, {1'b1, VEC[i][7:0]});
            check(rd_rises == r0 + 1, "R3 one drive read", rd_rises - r0, 1);
            host_cycle(1'b0, BASE + 10'd1, 8'h00, q, en);
            check(q == VEC[i][15:8] && en, "R4 high byte read", {en, q}, {1'b1, VEC[i][15:8]});
            check(rd_rises == r0 + 1, "R4 no drive read", rd_rises - r0, 1);
        end

        // R6: command register pass-through
        w0 = wr_rises;
        host_cycle(1'b1, BASE + 10'd6, 8'h5C, q, en);
        check(regs[3] == 16'h005C, "R6 cmd write reg3", regs[3], 16'h005C);
        check(wr_rises == w0 + 1, "R6 cmd write strobe", wr_rises - w0, 1);
        host_cycle(1'b1, BASE + 10'd14, 8'hE7, q, en);
        check(regs[7] == 16'h00E7, "R6 cmd write reg7", regs[7], 16'h00E7);
        r0 = rd_rises;
        host_cycle(1'b0, BASE + 10'd6, 8'h00, q, en);
        check(q == 8'h5C && rd_rises == r0 + 1, "R6 cmd read reg3", {rd_rises - r0, q}, {1, 8'h5C});

        // R7: odd command addresses are ignored
        w0 = wr_rises;
        host_cycle(1'b1, BASE + 10'd7, 8'h11, q, en);
        check(wr_rises == w0 && regs[3] == 16'h005C, "R7 odd write ignored", regs[3], 16'h005C);
        r0 = rd_rises;
        host_cycle(1'b0, BASE + 10'd7, 8'h00, q, en);
        check(q == 8'hFF && en && rd_rises == r0, "R7 odd read 0xFF", {rd_rises - r0, q}, {0, 8'hFF});

        // R2: outside the window
        w0 = wr_rises;
        r0 = rd_rises;
        host_cycle(1'b1, BASE + 10'h010, 8'h42, q, en);
        host_cycle(1'b0, BASE - 10'h002, 8'h00, q, en);
        check(wr_rises == w0 && rd_rises == r0 && !en, "R2 unselected",
              {wr_rises - w0, rd_rises - r0, en}, 0);

        // R11: command accesses between halves keep the held byte
        host_cycle(1'b1, BASE + 10'd0, 8'h34, q, en);
        host_cycle(1'b1, BASE + 10'd4, 8'h99, q, en);
        host_cycle(1'b0, BASE + 10'd6, 8'h00, q, en);
        host_cycle(1'b1, BASE + 10'd1, 8'h12, q, en);
        check(regs[0] == 16'h1234, "R11 write halves split", regs[0], 16'h1234);
        check(regs[2] == 16'h0099, "R11 cmd between halves", regs[2], 16'h0099);
        host_cycle(1'b0, BASE + 10'd0, 8'h00, q, en);
        host_cycle(1'b1, BASE + 10'd12, 8'h77, q, en);
        host_cycle(1'b0, BASE + 10'd1, 8'h00, q, en);
        check(q == 8'h12, "R11 read halves split", q, 8'h12);

        // R8, R9: release timing of a data-high write
        host_cycle(1'b1, BASE + 10'd0, 8'hC3, q, en);
        @(negedge clk);
        host_addr = BASE + 10'd1;
        host_din  = 8'h3C;
        repeat (2) @(negedge clk);
        host_wr = 1'b1;
        repeat (10) @(negedge clk);
        check(drv_wr && drv_reg == 3'd0 && drv_dout == 16'h3CC3, "R5 write data on bus",
              {drv_wr, drv_dout}, {1'b1, 16'h3CC3});
        host_wr = 1'b0;
        for (int s = 1; s <= 2 * HOLD + 4; s++) begin
            @(negedge clk);
            if (s == HOLD + 2) check(drv_wr == 1'b1, "R8 strobe still high", drv_wr, 1);
            if (s == HOLD + 3) begin
                check(drv_wr == 1'b0, "R8 strobe released", drv_wr, 0);
                check(drv_dout_en && drv_dout == 16'h3CC3, "R9 data held after strobe",
                      {drv_dout_en, drv_dout}, {1'b1, 16'h3CC3});
            end
            if (s == 2 * HOLD + 2) check(drv_dout_en == 1'b1, "R9 enable last hold cycle", drv_dout_en, 1);
            if (s == 2 * HOLD + 3) check(drv_dout_en == 1'b0, "R9 enable dropped", drv_dout_en, 0);
        end

        // R8, R10: read strobe release and register stability
        @(negedge clk);
        host_addr = BASE + 10'd6;
        repeat (2) @(negedge clk);
        host_rd = 1'b1;
        repeat (10) @(negedge clk);
        check(drv_rd && !drv_wr && drv_reg == 3'd3, "R10 single strobe reg3",
              {drv_rd, drv_wr, drv_reg}, {1'b1, 1'b0, 3'd3});
        host_rd = 1'b0;
        for (int s = 1; s <= HOLD + 4; s++) begin
            @(negedge clk);
            if (s == HOLD + 2) check(drv_rd == 1'b1, "R8 read strobe still high", drv_rd, 1);
            if (s == HOLD + 3) check(drv_rd == 1'b0, "R8 read strobe released", drv_rd, 0);
        end
        repeat (5) @(negedge clk);

        $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule